// File: doc/BRIEF.md
# Pulse-Driven Pitch Period Estimator

This block tracks the fundamental period of an audio signal from a train of peak events. An upstream peak finder presents a one-cycle `pulse_i` together with the 8-bit height of that peak on `amp_i`. A prescaled tick counts the time between peaks that pass the gating rules. A running estimate of the period is kept by halving the sum of each fresh measurement and the stored value. The estimate appears on `period_o`, and `period_vld_o` marks each cycle in which it changes.

Two rules gate which peaks take part. After a peak is taken, the block holds off for half of the current estimate, so harmonics that fall inside one period do not shorten the measurement. Once that hold-off ends, a peak must also clear an amplitude threshold. In the decaying mode this threshold starts at the height of the last peak taken and halves at fixed intervals, but it never falls below a constant floor. In the constant mode the floor alone is the threshold. A measurement that runs past the counter range is treated as lost, and tracking starts again.

Top module: `pitch_period_est`

## Requirements
- R1: The period counter advances once every 2^PRE_W clocks (256 by default), so a gap of N·2^PRE_W clocks between two taken peaks measures N or N−1 ticks.
- R2: After reset, the first peak that is taken only starts timing. It raises no strobe.
- R3: The next taken peak with an in-range measurement loads the estimate with the measurement itself. `period_vld_o` is high for exactly one cycle, the clock after the peak is sampled, and `period_o` carries the new value in that same cycle.
- R4: Each later taken peak sets the estimate to floor((measurement + estimate) / 2) and strobes as in R3.
- R5: After a taken peak with a valid estimate, peaks are ignored for (estimate >> 1) ticks. An ignored peak leaves `period_o` unchanged and raises no strobe.
- R6: With `decay_mode_i` = 0, a peak outside hold-off is taken exactly when `amp_i` ≥ FLOOR (16 by default). Peaks below FLOOR have no effect.
- R7: With `decay_mode_i` = 1, a peak outside hold-off is taken when `amp_i` ≥ the decaying threshold. This threshold is reloaded with the amplitude of every taken peak. Outside hold-off it halves every 2^DECAY_W ticks (64 by default), and it is never below FLOOR.
- R8: The period counter saturates at 2^PER_W−1 (1023). A peak taken while the counter is saturated raises no strobe and discards the estimate. The following taken peak loads the estimate directly, without averaging.
- R9: During and after reset, `period_o` = 0 and `period_vld_o` = 0.
- R10: `period_o` holds its value in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (24 MHz in the intended use) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 1 | One-cycle peak event from the peak finder |
| amp_i | input | AMP_W (8) | Height of the peak presented with `pulse_i` |
| decay_mode_i | input | 1 | 1 selects the decaying threshold, 0 the constant floor |
| period_o | output | PER_W (10) | Current period estimate in prescaled ticks |
| period_vld_o | output | 1 | One-cycle strobe when `period_o` takes a new estimate |

## Verification
The embedded properties check on every cycle that the tick never fires on two clocks in a row and that a saturated counter stays saturated. They also check that the hold-off count only falls between taken peaks, that each averaged estimate lies between the old estimate and the measurement, that every strobe follows a taken peak, and that the threshold never rises without a reload and never drops below the floor. Whether a particular peak should be taken, the exact averaged value, the order of events after saturation, and how the two threshold modes interact over long gaps can only be seen in the bench's scenarios. There a reference model driven by the same stimulus predicts `period_o` and `period_vld_o` in every cycle.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
   // Tracking phase of the estimator
   typedef enum logic [1:0] {
      TRK_IDLE   = 2'd0,  // nothing taken since reset
      TRK_ARMED  = 2'd1,  // timing running, no estimate yet
      TRK_LOCKED = 2'd2   // estimate valid, averaging active
   } trk_state_e;
endpackage

// File: rtl/ppe_prescaler.sv
module ppe_prescaler #(
   parameter int unsigned PRE_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   if (PRE_W < 1) begin : g_bad_pre
      $error("ppe_prescaler: PRE_W must be at least 1");
   end

   logic [PRE_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   assign tick_o = &div_q;

   // R1
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/ppe_threshold.sv
module ppe_threshold #(
   parameter int unsigned AMP_W    = 8,
   parameter int unsigned FLOOR    = 16,
   parameter int unsigned DECAY_W  = 6,
   parameter bit          DECAY_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             blank_i,
   input  logic             load_i,
   input  logic [AMP_W-1:0] amp_i,
   input  logic             mode_i,
   output logic [AMP_W-1:0] thr_o
);
   localparam logic [AMP_W-1:0] FLOOR_V = AMP_W'(FLOOR);

   if (AMP_W < 2) begin : g_bad_amp
      $error("ppe_threshold: AMP_W must be at least 2");
   end
   if (FLOOR >= (1 << AMP_W)) begin : g_bad_floor
      $error("ppe_threshold: FLOOR does not fit in AMP_W bits");
   end
   if (DECAY_W < 1) begin : g_bad_decay
      $error("ppe_threshold: DECAY_W must be at least 1");
   end

   if (DECAY_EN) begin : g_decay
      logic [AMP_W-1:0]   thr_q;
      logic [DECAY_W-1:0] age_q;
      logic [AMP_W-1:0]   halved;

      assign halved = thr_q >> 1;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            thr_q <= FLOOR_V;
            age_q <= '0;
         end else if (load_i) begin
            thr_q <= (amp_i < FLOOR_V) ? FLOOR_V : amp_i;
            age_q <= '0;
         end else if (tick_i && !blank_i) begin
            age_q <= age_q + 1'b1;
            if (&age_q) thr_q <= (halved < FLOOR_V) ? FLOOR_V : halved;
         end
      end

      assign thr_o = mode_i ? thr_q : FLOOR_V;

      // R7
      thr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
         thr_q >= FLOOR_V);
      // R7
      thr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !load_i |=> thr_q <= $past(thr_q));
   end else begin : g_const
      assign thr_o = FLOOR_V;
   end
endmodule

// File: rtl/ppe_tracker.sv
module ppe_tracker
   import ppe_pkg::*;
#(
   parameter int unsigned PER_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             accept_i,
   output logic [PER_W-1:0] period_o,
   output logic             vld_o,
   output logic             blank_o
);
   localparam logic [PER_W-1:0] CNT_MAX = '1;

   if (PER_W < 2) begin : g_bad_per
      $error("ppe_tracker: PER_W must be at least 2");
   end

   trk_state_e       st_q;
   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] est_q;
   logic [PER_W-1:0] blank_q;
   logic             vld_q;
   logic [PER_W:0]   sum;
   logic [PER_W-1:0] avg;
   logic             sat;

   assign sum = {1'b0, cnt_q} + {1'b0, est_q};
   assign avg = sum[PER_W:1];
   assign sat = (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= TRK_IDLE;
         cnt_q   <= '0;
         est_q   <= '0;
         blank_q <= '0;
         vld_q   <= 1'b0;
      end else if (accept_i) begin
         cnt_q   <= '0;
         vld_q   <= 1'b0;
         blank_q <= '0;
         if (st_q == TRK_IDLE || sat) begin
            st_q <= TRK_ARMED;
         end else if (st_q == TRK_ARMED) begin
            st_q    <= TRK_LOCKED;
            est_q   <= cnt_q;
            blank_q <= cnt_q >> 1;
            vld_q   <= 1'b1;
         end else begin
            est_q   <= avg;
            blank_q <= avg >> 1;
            vld_q   <= 1'b1;
         end
      end else begin
         vld_q <= 1'b0;
         if (tick_i) begin
            if (!sat)              cnt_q   <= cnt_q + 1'b1;
            if (blank_q != '0)     blank_q <= blank_q - 1'b1;
         end
      end
   end

   assign period_o = est_q;
   assign vld_o    = vld_q;
   assign blank_o  = (blank_q != '0);

   // R8
   cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sat && !accept_i) |=> sat);
   // R5
   blank_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !accept_i |=> blank_q <= $past(blank_q));
   // R4
   avg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && $past(st_q) == TRK_LOCKED) |->
         ((est_q >= $past(cnt_q)) || (est_q >= $past(est_q))) &&
         ((est_q <= $past(cnt_q)) || (est_q <= $past(est_q))));
   // R3
   vld_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> $past(accept_i));
endmodule

// File: rtl/pitch_period_est.sv
module pitch_period_est #(
   parameter int unsigned PRE_W    = 8,
   parameter int unsigned PER_W    = 10,
   parameter int unsigned AMP_W    = 8,
   parameter int unsigned FLOOR    = 16,
   parameter int unsigned DECAY_W  = 6,
   parameter bit          DECAY_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pulse_i,
   input  logic [AMP_W-1:0] amp_i,
   input  logic             decay_mode_i,
   output logic [PER_W-1:0] period_o,
   output logic             period_vld_o
);
   logic             tick;
   logic             blank;
   logic             accept;
   logic [AMP_W-1:0] thr;

   ppe_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   ppe_threshold #(
      .AMP_W    (AMP_W),
      .FLOOR    (FLOOR),
      .DECAY_W  (DECAY_W),
      .DECAY_EN (DECAY_EN)
   ) u_thr (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .blank_i (blank),
      .load_i  (accept),
      .amp_i   (amp_i),
      .mode_i  (decay_mode_i),
      .thr_o   (thr)
   );

   assign accept = pulse_i && !blank && (amp_i >= thr);

   ppe_tracker #(.PER_W(PER_W)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .accept_i (accept),
      .period_o (period_o),
      .vld_o    (period_vld_o),
      .blank_o  (blank)
   );

   // R5
   no_take_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_i && blank) |=> !period_vld_o);
endmodule

// File: tb/pitch_period_est_tb.sv
module pitch_period_est_tb;
   localparam int PRE_W   = 3;
   localparam int PER_W   = 10;
   localparam int AMP_W   = 8;
   localparam int FLOOR   = 16;
   localparam int DECAY_W = 6;
   localparam int DIV     = 1 << PRE_W;
   localparam int CMAX    = (1 << PER_W) - 1;
   localparam int AGE_MAX = (1 << DECAY_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pulse_i = 1'b0;
   logic [AMP_W-1:0] amp_i = '0;
   logic             decay_mode_i = 1'b0;
   logic [PER_W-1:0] period_o;
   logic             period_vld_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pitch_period_est #(
      .PRE_W(PRE_W), .PER_W(PER_W), .AMP_W(AMP_W),
      .FLOOR(FLOOR), .DECAY_W(DECAY_W), .DECAY_EN(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .amp_i(amp_i),
      .decay_mode_i(decay_mode_i), .period_o(period_o),
      .period_vld_o(period_vld_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Reference model built from the requirements
   int m_pre, m_cnt, m_est, m_blank, m_st, m_thr, m_age, m_per;
   bit m_vld;

   always @(posedge clk) begin
      bit tk, take;
      int thr_eff;
      if (!rst_n) begin
         m_pre = 0; m_cnt = 0; m_est = 0; m_blank = 0; m_st = 0;
         m_thr = FLOOR; m_age = 0; m_per = 0; m_vld = 0;
      end else begin
         tk = (m_pre == DIV - 1);
         m_pre = (m_pre + 1) % DIV;
         thr_eff = decay_mode_i ? m_thr : FLOOR;
         take = pulse_i && (m_blank == 0) && (int'(amp_i) >= thr_eff);
         m_vld = 0;
         if (take) begin
            if (m_st == 0 || m_cnt == CMAX) begin
               m_st = 1; m_blank = 0;
            end else if (m_st == 1) begin
               m_st = 2; m_est = m_cnt; m_vld = 1; m_blank = m_est / 2;
            end else begin
               m_est = (m_cnt + m_est) / 2; m_vld = 1; m_blank = m_est / 2;
            end
            m_cnt = 0;
            m_thr = (int'(amp_i) < FLOOR) ? FLOOR : int'(amp_i);
            m_age = 0;
            if (m_vld) m_per = m_est;
         end else if (tk) begin
            if (m_cnt < CMAX) m_cnt++;
            if (m_blank != 0) m_blank--;
            else begin
               if (m_age == AGE_MAX) begin
                  m_age = 0;
                  m_thr = (m_thr / 2 < FLOOR) ? FLOOR : m_thr / 2;
               end else m_age++;
            end
         end
      end
   end

   // R10 / R3 / R4: every cycle the ports must match the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (period_vld_o !== m_vld)
            chk(1'b0, "R3 strobe", int'(period_vld_o), int'(m_vld));
         else
            chk(period_o === PER_W'(m_per), "R10 period", int'(period_o), m_per);
      end
   end

   // Directed pulse: returns what the ports show in the strobe cycle
   task automatic peak(input int amp, output bit got_v, output int got_p);
      @(negedge clk);
      pulse_i = 1'b1;
      amp_i = AMP_W'(amp);
      @(negedge clk);
      pulse_i = 1'b0;
      got_v = period_vld_o;
      got_p = int'(period_o);
   endtask

   task automatic wait_ticks(input int n);
      repeat (n * DIV - 1) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      bit v;
      int p, prev;
      void'($urandom(32'h1d5e));

      repeat (3) @(negedge clk);
      // R9
      chk(period_o == '0, "R9 period in reset", int'(period_o), 0);
      chk(!period_vld_o, "R9 strobe in reset", int'(period_vld_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(period_o == '0, "R9 period after reset", int'(period_o), 0);

      // constant floor mode
      decay_mode_i = 1'b0;
      peak(100, v, p);
      chk(!v, "R2 first peak no strobe", int'(v), 0);
      wait_ticks(10);
      peak(100, v, p);
      chk(v, "R3 second peak strobes", int'(v), 1);
      chk(p == 9 || p == 10, "R1 R3 direct load", p, 10);
      prev = p;
      wait_ticks(20);
      peak(100, v, p);
      chk(v && (p == (prev + 20) / 2 || p == (prev + 19) / 2), "R4 averaged", p, (prev + 20) / 2);
      prev = p;
      wait_ticks(2);
      peak(200, v, p);
      chk(!v && p == prev, "R5 held-off peak ignored", p, prev);
      wait_ticks(30);
      peak(FLOOR - 1, v, p);
      chk(!v && p == prev, "R6 below floor ignored", p, prev);
      peak(FLOOR, v, p);
      chk(v, "R6 at floor taken", int'(v), 1);

      // decaying threshold
      decay_mode_i = 1'b1;
      wait_ticks(30);
      peak(200, v, p);
      chk(v, "R7 reload peak taken", int'(v), 1);
      prev = p;
      wait_ticks(20);
      peak(150, v, p);
      chk(!v && p == prev, "R7 below fresh threshold", p, prev);
      wait_ticks(210);
      peak(30, v, p);
      chk(v, "R7 taken after decay", int'(v), 1);

      // saturation
      decay_mode_i = 1'b0;
      wait_ticks(CMAX + 80);
      prev = int'(period_o);
      peak(100, v, p);
      chk(!v && p == prev, "R8 saturated peak no strobe", p, prev);
      wait_ticks(12);
      peak(100, v, p);
      chk(v && (p == 11 || p == 12), "R8 direct reload", p, 12);

      // random mix
      for (int i = 0; i < 400; i++) begin
         decay_mode_i = (i / 100) % 2;
         repeat ($urandom_range(1, 300)) @(negedge clk);
         pulse_i = 1'b1;
         amp_i = AMP_W'($urandom_range(0, 255));
         @(negedge clk);
         pulse_i = 1'b0;
      end
      repeat (10) @(negedge clk);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule